// File: doc/BRIEF.md
# Blocked Cube Read Address Generator

This block turns a handful of configuration values into an ordered stream of memory read commands. The commands walk a hyperspectral cube one rectangular block at a time. The cube sits in memory as rows of pixels, and every pixel is `cfg_depth` consecutive components. Each command names a byte address and a byte length covering one row of one block, which is all the components of that row's pixels taken together. A downstream data mover fetches the data, and the block itself carries no data.

After a start pulse the block begins at the base byte address plus the component offset, scaled to bytes. It emits every row of a block, then moves to the next block. Blocks are walked with X as the inner loop. The step between blocks is a programmable skip, and a separate skip is used after the last X block of each block row. All dimensions and block counts are given as minus-one values. Commands leave on a valid/ready handshake, and a one-cycle done pulse marks the end of the walk.

An optional split mode serves a small data mover that takes at most 256 bytes per request. In that mode a long row is cut into consecutive pieces. The component width is a parameter and must be a multiple of 8 bits.

Top module: `cube_agen`

## Requirements
- R1: While reset is high and in the first cycle after it, `cmd_valid` and `done` are 0.
- R2: A `start` pulse seen while idle raises `cmd_valid` in the next cycle. The first command address is `cfg_base + cfg_offset*CB`, where CB = COMP_W/8 bytes per component.
- R3: Each block yields `cfg_blk_h_m1+1` row commands. Consecutive rows start `cfg_row_stride*CB` bytes apart, and each row is `(cfg_blk_w_m1+1)*cfg_depth*CB` bytes long.
- R4: Blocks advance X-first. The first address of the next block is the first address of the current block plus `cfg_blk_skip*CB`. When the current block is the last X block (index `cfg_xblk_m1`), `cfg_last_skip*CB` is used instead.
- R5: One walk covers `(cfg_yblk_m1+1)*(cfg_xblk_m1+1)` blocks and then stops issuing commands.
- R6: With `cfg_split`=1, a row longer than 256 bytes is issued as 256-byte pieces at rising addresses, 256 apart, followed by the remainder. A row of 256 bytes or less, and any row with `cfg_split`=0, is issued as a single command.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_addr` and `cmd_len` hold their values. The walk advances only on an accepted command, so no command is dropped or repeated.
- R8: `done` is high for exactly one cycle: the cycle after the final command is accepted. In that cycle `cmd_valid` is 0.
- R9: A `start` pulse while a walk is in progress has no effect on the command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| cfg_split | input | 1 | Cut rows into pieces of at most 256 bytes |
| cfg_base | input | 32 | Cube base byte address |
| cfg_offset | input | 32 | Start offset in components |
| cfg_row_stride | input | 20 | Row-to-row distance in components |
| cfg_blk_w_m1 | input | 12 | Block width in pixels minus one |
| cfg_blk_h_m1 | input | 12 | Block height in rows minus one |
| cfg_depth | input | 8 | Components per pixel |
| cfg_blk_skip | input | 16 | Components from one block start to the next |
| cfg_last_skip | input | 16 | Skip used after the last X block |
| cfg_xblk_m1 | input | 9 | Blocks in X minus one |
| cfg_yblk_m1 | input | 9 | Blocks in Y minus one |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_addr | output | 32 | Command byte address |
| cmd_len | output | 32 | Command byte length |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
A 2x2 block walk with several rows per block and an always-ready consumer separates a wrong row stride, a wrong normal skip and a wrong last-block skip, because each of them shows up at a distinct address. A three-block single-row walk under a periodic stall pattern shows whether addresses are held while stalled and whether a start pulse during the walk disturbs it. Split runs with 400-, 256- and 512-byte rows, plus a 400-byte row with splitting off, tell apart an off-by-one in the 256-byte boundary, a missing remainder, and a split that applies when it should not.

// File: rtl/cube_agen_pkg.sv
package cube_agen_pkg;
    localparam int ADDR_W  = 32;
    localparam int LEN_W   = 32;
    localparam int ROW_W   = 20;
    localparam int DIM_W   = 12;
    localparam int DEPTH_W = 8;
    localparam int SKIP_W  = 16;
    localparam int NBLK_W  = 9;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic {ST_IDLE, ST_RUN} walk_state_e;

    typedef struct packed {
        addr_t blk_start;
        addr_t row_start;
        addr_t piece;
    } addr_regs_t;

    function automatic addr_t comps_to_bytes(input addr_t comps, input int unsigned cb);
        return comps * addr_t'(cb);
    endfunction
endpackage

// File: rtl/cube_agen_walker.sv
module cube_agen_walker
    import cube_agen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [DIM_W-1:0]  h_m1,
    input  logic [NBLK_W-1:0] nx_m1,
    input  logic [NBLK_W-1:0] ny_m1,
    output logic              row_last,
    output logic              x_last,
    output logic              all_last
);
    logic [DIM_W-1:0]  row_q;
    logic [NBLK_W-1:0] bx_q;
    logic [NBLK_W-1:0] by_q;

    assign row_last = (row_q == h_m1);
    assign x_last   = (bx_q == nx_m1);
    assign all_last = row_last && x_last && (by_q == ny_m1);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            row_q <= '0;
            bx_q  <= '0;
            by_q  <= '0;
        end else if (adv) begin
            if (!row_last) begin
                row_q <= row_q + 1'b1;
            end else begin
                row_q <= '0;
                if (!x_last) begin
                    bx_q <= bx_q + 1'b1;
                end else begin
                    bx_q <= '0;
                    by_q <= by_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cube_agen_chunker.sv
module cube_agen_chunker
    import cube_agen_pkg::*;
#(
    parameter int CHUNK_BYTES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  len_t len_full,
    input  logic accept,
    input  logic split_en,
    output len_t cur_len,
    output logic more
);
    localparam len_t CHUNK = len_t'(CHUNK_BYTES);

    len_t left_q;

    assign more    = split_en && (left_q > CHUNK);
    assign cur_len = more ? CHUNK : left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (accept && more) begin
            left_q <= left_q - CHUNK;
        end else if (load) begin
            left_q <= len_full;
        end
    end
endmodule

// File: rtl/cube_agen.sv
module cube_agen
    import cube_agen_pkg::*;
#(
    parameter int COMP_W      = 16,
    parameter int CHUNK_BYTES = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               cfg_split,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [31:0]        cfg_offset,
    input  logic [ROW_W-1:0]   cfg_row_stride,
    input  logic [DIM_W-1:0]   cfg_blk_w_m1,
    input  logic [DIM_W-1:0]   cfg_blk_h_m1,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic [SKIP_W-1:0]  cfg_blk_skip,
    input  logic [SKIP_W-1:0]  cfg_last_skip,
    input  logic [NBLK_W-1:0]  cfg_xblk_m1,
    input  logic [NBLK_W-1:0]  cfg_yblk_m1,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [LEN_W-1:0]   cmd_len,
    output logic               done
);
    localparam int unsigned CB = COMP_W / 8;

    walk_state_e state_q;
    addr_regs_t  ar_q;
    logic        done_q;

    logic  go, accept, more, row_done;
    logic  row_last, x_last, all_last;
    addr_t first_b, stride_b, skip_b;
    len_t  row_len_b, cur_len;

    assign go       = (state_q == ST_IDLE) && start;
    assign accept   = (state_q == ST_RUN) && cmd_ready;
    assign row_done = accept && !more;

    assign first_b   = cfg_base + comps_to_bytes(addr_t'(cfg_offset), CB);
    assign stride_b  = comps_to_bytes(addr_t'(cfg_row_stride), CB);
    assign skip_b    = comps_to_bytes(addr_t'(x_last ? cfg_last_skip : cfg_blk_skip), CB);
    assign row_len_b = (len_t'(cfg_blk_w_m1) + len_t'(1)) * len_t'(cfg_depth) * len_t'(CB);

    cube_agen_walker walker_i (
        .clk      (clk),
        .rst      (rst),
        .load     (go),
        .adv      (row_done),
        .h_m1     (cfg_blk_h_m1),
        .nx_m1    (cfg_xblk_m1),
        .ny_m1    (cfg_yblk_m1),
        .row_last (row_last),
        .x_last   (x_last),
        .all_last (all_last)
    );

    cube_agen_chunker #(.CHUNK_BYTES(CHUNK_BYTES)) chunker_i (
        .clk      (clk),
        .rst      (rst),
        .load     (go || row_done),
        .len_full (row_len_b),
        .accept   (accept),
        .split_en (cfg_split),
        .cur_len  (cur_len),
        .more     (more)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ar_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                state_q      <= ST_RUN;
                ar_q.blk_start <= first_b;
                ar_q.row_start <= first_b;
                ar_q.piece     <= first_b;
            end else if (accept) begin
                if (more) begin
                    ar_q.piece <= ar_q.piece + addr_t'(CHUNK_BYTES);
                end else if (all_last) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end else if (row_last) begin
                    ar_q.blk_start <= ar_q.blk_start + skip_b;
                    ar_q.row_start <= ar_q.blk_start + skip_b;
                    ar_q.piece     <= ar_q.blk_start + skip_b;
                end else begin
                    ar_q.row_start <= ar_q.row_start + stride_b;
                    ar_q.piece     <= ar_q.row_start + stride_b;
                end
            end
        end
    end

    assign cmd_valid = (state_q == ST_RUN);
    assign cmd_addr  = ar_q.piece;
    assign cmd_len   = cur_len;
    assign done      = done_q;
endmodule

// File: rtl/cube_agen_checker.sv
module cube_agen_checker #(
    parameter int CHUNK_BYTES = 256
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_split,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [31:0] cmd_addr,
    input logic [31:0] cmd_len,
    input logic        done
);
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_valid); // R8
    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(cmd_valid && cmd_ready)); // R8
    AST_PIECE_CAP: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cfg_split) |-> (cmd_len <= 32'(CHUNK_BYTES))); // R6
endmodule

bind cube_agen cube_agen_checker #(.CHUNK_BYTES(CHUNK_BYTES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_split (cfg_split),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .done      (done)
);

// File: tb/cube_agen_tb_top.sv
module cube_agen_tb_top;
    localparam int CB = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic cfg_split = 1'b0;
    logic [31:0] cfg_base = '0, cfg_offset = '0;
    logic [19:0] cfg_row_stride = '0;
    logic [11:0] cfg_blk_w_m1 = '0, cfg_blk_h_m1 = '0;
    logic [7:0]  cfg_depth = '0;
    logic [15:0] cfg_blk_skip = '0, cfg_last_skip = '0;
    logic [8:0]  cfg_xblk_m1 = '0, cfg_yblk_m1 = '0;
    logic cmd_ready = 1'b0;
    logic cmd_valid, done;
    logic [31:0] cmd_addr, cmd_len;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cube_agen #(.COMP_W(16), .CHUNK_BYTES(256)) dut_i (
        .clk(clk), .rst(rst), .start(start), .cfg_split(cfg_split),
        .cfg_base(cfg_base), .cfg_offset(cfg_offset), .cfg_row_stride(cfg_row_stride),
        .cfg_blk_w_m1(cfg_blk_w_m1), .cfg_blk_h_m1(cfg_blk_h_m1), .cfg_depth(cfg_depth),
        .cfg_blk_skip(cfg_blk_skip), .cfg_last_skip(cfg_last_skip),
        .cfg_xblk_m1(cfg_xblk_m1), .cfg_yblk_m1(cfg_yblk_m1),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Walk run: mode 0 = always ready, 1 = stall every third cycle; poke = start during walk.
    task automatic run_walk(input string req, input int mode, input bit poke);
        logic [31:0] ea[$];
        logic [31:0] el[$];
        logic [31:0] anchor, a, left, prev_a, prev_l;
        int idx, cyc;
        bit stalled;
        anchor = cfg_base + cfg_offset * CB;
        for (int by = 0; by <= int'(cfg_yblk_m1); by++) begin
            for (int bx = 0; bx <= int'(cfg_xblk_m1); bx++) begin
                for (int r = 0; r <= int'(cfg_blk_h_m1); r++) begin
                    a = anchor + 32'(r) * 32'(cfg_row_stride) * CB;
                    left = (32'(cfg_blk_w_m1) + 1) * 32'(cfg_depth) * CB;
                    while (cfg_split && left > 256) begin
                        ea.push_back(a); el.push_back(256);
                        a += 256; left -= 256;
                    end
                    ea.push_back(a); el.push_back(left);
                end
                anchor += 32'((bx == int'(cfg_xblk_m1)) ? cfg_last_skip : cfg_blk_skip) * CB;
            end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(cmd_valid == 1'b1, {req, " R2 valid after start"}, 32'(cmd_valid), 1);
        check(cmd_addr == ea[0], {req, " R2 first address"}, cmd_addr, ea[0]);
        idx = 0; cyc = 0; stalled = 0; prev_a = '0; prev_l = '0;
        while (idx < ea.size() && cyc < 5000) begin
            start = (poke && cyc == 3);
            cmd_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
            if (stalled) begin
                check(cmd_addr == prev_a && cmd_len == prev_l, {req, " R7 hold"}, cmd_addr, prev_a);
            end
            check(done == 1'b0, {req, " R8 early done"}, 32'(done), 0);
            if (cmd_valid && cmd_ready) begin
                check(cmd_addr == ea[idx], {req, " address"}, cmd_addr, ea[idx]);
                check(cmd_len == el[idx], {req, " length"}, cmd_len, el[idx]);
                idx++;
            end
            stalled = cmd_valid && !cmd_ready;
            prev_a = cmd_addr; prev_l = cmd_len;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        cmd_ready = 1'b0;
        check(idx == ea.size(), {req, " R5 command count"}, 32'(idx), 32'(ea.size()));
        check(done == 1'b1, {req, " R8 done pulse"}, 32'(done), 1);
        check(cmd_valid == 1'b0, {req, " R8 idle at done"}, 32'(cmd_valid), 0);
        @(negedge clk);
        check(done == 1'b0, {req, " R8 done one cycle"}, 32'(done), 0);
        check(cmd_valid == 1'b0, {req, " R5 no extra command"}, 32'(cmd_valid), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(cmd_valid == 1'b0 && done == 1'b0, "R1 in reset", {cmd_valid, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_valid == 1'b0 && done == 1'b0, "R1 after reset", {cmd_valid, done}, 0);
    endtask

    task automatic t_grid();
        cfg_split = 0; cfg_base = 32'h1000; cfg_offset = 5; cfg_row_stride = 40;
        cfg_blk_w_m1 = 2; cfg_blk_h_m1 = 1; cfg_depth = 3;
        cfg_blk_skip = 9; cfg_last_skip = 100; cfg_xblk_m1 = 1; cfg_yblk_m1 = 1;
        run_walk("R3 R4 grid", 0, 0);
    endtask

    task automatic t_stall();
        cfg_split = 0; cfg_base = 32'h8000; cfg_offset = 0; cfg_row_stride = 64;
        cfg_blk_w_m1 = 3; cfg_blk_h_m1 = 0; cfg_depth = 4;
        cfg_blk_skip = 16; cfg_last_skip = 7; cfg_xblk_m1 = 2; cfg_yblk_m1 = 0;
        run_walk("R7 R9 stall", 1, 1);
    endtask

    task automatic t_split();
        cfg_split = 1; cfg_base = 32'h2000; cfg_offset = 3; cfg_row_stride = 1000;
        cfg_blk_h_m1 = 1; cfg_depth = 2; cfg_blk_skip = 200; cfg_last_skip = 300;
        cfg_xblk_m1 = 0; cfg_yblk_m1 = 1;
        cfg_blk_w_m1 = 99;  run_walk("R6 split 400", 0, 0);
        cfg_blk_w_m1 = 63;  run_walk("R6 split 256", 0, 0);
        cfg_blk_w_m1 = 127; run_walk("R6 split 512", 1, 0);
        cfg_split = 0; cfg_blk_w_m1 = 99; run_walk("R6 nosplit 400", 0, 0);
    endtask

    initial begin
        t_reset();
        t_grid();
        t_stall();
        t_split();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule